// File: doc/BRIEF.md
# Serial Clock Hold Timeout Watchdog

This block limits how long a byte on an I2C-style serial bus may stall while the bus master keeps the clock line held low. It runs on the peripheral bus clock. A free-running prescaler counter supplies a one-cycle tick whose rate is chosen by a power-of-two tap select. A down-counter is re-armed with a programmable reload value at every byte boundary, whether a start condition or the acknowledge of the previous byte. It counts ticks only while the clock-hold indication is asserted and the block is enabled.

When the count runs out, a sticky timeout flag is raised. Software picks the reload value as the wanted timeout divided by the tick period, which is 2^(sel+1) bus clock cycles. The flag clears at the next byte boundary or when the block is disabled. Register decoding and the serial shift logic sit outside this block.

Top module: `sclhold_timeout_timer`

## Requirements
- R1: A synchronous active-high reset clears the prescaler counter, the down-counter and the flag. Holding the clock with the block enabled before any byte boundary therefore raises the flag on the first tick.
- R2: The prescaler is a 16-bit counter that starts at 0 after reset and adds one every cycle. The tick is high for exactly one cycle, in each cycle where the counter value modulo 2^(sel+1) equals 2^sel. This is the rising edge of counter bit sel, so ticks come every 2^(sel+1) cycles.
- R3: A `byte_start` or `ack_evt` pulse loads `reload_val` into the down-counter and clears the flag at the next clock edge.
- R4: The down-counter decreases by one only at an edge where `tmr_en`, `scl_hold` and the tick are all high. Otherwise it holds its value.
- R5: The flag is set at the edge of an enabled, held tick that finds the down-counter at 1 or 0. With reload value N ≥ 1 it rises at the Nth held tick after the load. With N = 0 it rises at the first held tick.
- R6: The down-counter saturates at 0. Once set, the flag stays high while the hold continues, until a byte boundary or a disable.
- R7: While `tmr_en` is 0, the flag is 0 from the next edge on and the down-counter does not count. Loads still take effect.
- R8: A byte boundary pulse takes priority over a tick in the same cycle. A count is never decremented or timed out in a cycle that reloads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Timer enable; 0 forces the flag low |
| div_sel | input | 4 | Prescaler tap select, tick every 2^(div_sel+1) cycles |
| reload_val | input | 15 | Value loaded at each byte boundary |
| byte_start | input | 1 | One-cycle pulse on a start condition |
| ack_evt | input | 1 | One-cycle pulse on the acknowledge of the previous byte |
| scl_hold | input | 1 | High while the master keeps the clock line low |
| timeout_flag | output | 1 | Registered, sticky timeout indication |

## Verification
The hardest situation to reach is a byte boundary pulse that lands in exactly the cycle where a held tick would have decremented or expired the count. The prescaler is not observable and is never reset except at reset. The bench therefore tracks its phase by counting cycles from reset release. It then repeats boundary pulses on every cycle of a long hold, so that some of them line up with ticks, and it checks that the flag never rises. The same phase tracking places the tick-by-tick expiry of small reload values, including zero, at both a fast and a slow tap.

// File: rtl/sclhold_timeout_pkg.sv
package sclhold_timeout_pkg;
  localparam int DEF_PRE_W = 16;
  localparam int DEF_CNT_W = 15;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2
  } cnt_action_e;
endpackage

// File: rtl/sclhold_prescaler.sv
module sclhold_prescaler #(
  parameter int PRE_W = 16,
  parameter int SEL_W = $clog2(PRE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] free_q;
  logic [PRE_W-1:0] low_mask;

  always_ff @(posedge clk) begin
    if (rst) free_q <= '0;
    else     free_q <= free_q + 1'b1;
  end

  // Rising edge of the selected bit: bit set, all lower bits clear.
  always_comb begin
    low_mask = (PRE_W'(1) << sel) - PRE_W'(1);
    tick     = free_q[sel] && ((free_q & low_mask) == '0);
  end
endmodule

// File: rtl/sclhold_countdown.sv
module sclhold_countdown
  import sclhold_timeout_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  cnt_action_e act;
  logic        expire;

  always_comb begin
    if (load)                    act = ACT_LOAD;
    else if (en && hold && tick) act = ACT_DEC;
    else                         act = ACT_IDLE;
    expire = (act == ACT_DEC) && (cnt <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case (act)
        ACT_LOAD: cnt <= reload;
        ACT_DEC:  if (cnt != '0) cnt <= cnt - 1'b1;
        default:  cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    flag <= 1'b0;
    else if (!en)               flag <= 1'b0;
    else if (act == ACT_LOAD)   flag <= 1'b0;
    else if (expire)            flag <= 1'b1;
  end
endmodule

// File: rtl/sclhold_timeout_timer.sv
module sclhold_timeout_timer
  import sclhold_timeout_pkg::*;
#(
  parameter int PRE_W = DEF_PRE_W,
  parameter int CNT_W = DEF_CNT_W,
  parameter int SEL_W = $clog2(PRE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmr_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             byte_start,
  input  logic             ack_evt,
  input  logic             scl_hold,
  output logic             timeout_flag
);
  logic             tick;
  logic             byte_edge;
  logic [CNT_W-1:0] down_cnt;

  assign byte_edge = byte_start | ack_evt;

  sclhold_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .sel  (div_sel),
    .tick (tick)
  );

  sclhold_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk    (clk),
    .rst    (rst),
    .en     (tmr_en),
    .load   (byte_edge),
    .hold   (scl_hold),
    .tick   (tick),
    .reload (reload_val),
    .cnt    (down_cnt),
    .flag   (timeout_flag)
  );
endmodule

// File: rtl/sclhold_timeout_chk.sv
module sclhold_timeout_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             tmr_en,
  input logic             scl_hold,
  input logic             byte_start,
  input logic             ack_evt,
  input logic [CNT_W-1:0] reload_val,
  input logic             timeout_flag,
  input logic [CNT_W-1:0] cnt,
  input logic             tick
);
  logic ld;
  assign ld = byte_start | ack_evt;

  // R3
  load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (!timeout_flag && cnt == $past(reload_val)));

  // R4
  no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !(tmr_en && scl_hold && tick)) |=> $stable(cnt));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_flag) |-> $past(tmr_en && scl_hold && tick && !ld));

  // R6
  floor_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !ld) |=> cnt == '0);

  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> !timeout_flag);

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && tick && scl_hold && tmr_en) |=> (cnt == $past(reload_val) && !timeout_flag));
endmodule

bind sclhold_timeout_timer sclhold_timeout_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tmr_en       (tmr_en),
  .scl_hold     (scl_hold),
  .byte_start   (byte_start),
  .ack_evt      (ack_evt),
  .reload_val   (reload_val),
  .timeout_flag (timeout_flag),
  .cnt          (down_cnt),
  .tick         (tick)
);

// File: tb/sclhold_timeout_timer_bench.sv
module sclhold_timeout_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tmr_en = 1'b0;
  logic [3:0]  div_sel = '0;
  logic [14:0] reload_val = '0;
  logic        byte_start = 1'b0;
  logic        ack_evt = 1'b0;
  logic        scl_hold = 1'b0;
  logic        timeout_flag;

  always #10 clk = ~clk;  // 50 MHz

  sclhold_timeout_timer u_sclhold_timeout_timer (
    .clk(clk), .rst(rst), .tmr_en(tmr_en), .div_sel(div_sel),
    .reload_val(reload_val), .byte_start(byte_start), .ack_evt(ack_evt),
    .scl_hold(scl_hold), .timeout_flag(timeout_flag)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit exp_q[$];
  int req_q[$];

  // Requirement-level reference state
  int unsigned m_pre = 0;
  int unsigned m_cnt = 0;
  bit          m_flag = 1'b0;

  bit          c_en = 1'b0;
  int unsigned c_sel = 0;
  int unsigned c_rel = 0;

  task automatic step(input bit rs, input bit bs, input bit ak, input bit hd, input int req);
    bit tk;
    bit ld;
    @(negedge clk);
    rst = rs; byte_start = bs; ack_evt = ak; scl_hold = hd;
    tmr_en = c_en; div_sel = 4'(c_sel); reload_val = 15'(c_rel);
    @(posedge clk);
    if (rs) begin
      m_pre = 0; m_cnt = 0; m_flag = 1'b0;  // R1
    end else begin
      tk = ((m_pre % (32'd1 << (c_sel + 1))) == (32'd1 << c_sel));  // R2
      ld = bs || ak;
      if (!c_en)                       m_flag = 1'b0;  // R7
      else if (ld)                     m_flag = 1'b0;  // R3 R8
      else if (hd && tk && m_cnt <= 1) m_flag = 1'b1;  // R5 R6
      if (ld)                          m_cnt = c_rel;  // R3 R8
      else if (c_en && hd && tk && m_cnt != 0) m_cnt = m_cnt - 1;  // R4 R6
      m_pre = (m_pre + 1) & 32'hFFFF;
    end
    exp_q.push_back(m_flag);
    req_q.push_back(req);
  endtask

  // Monitor: compare each expected item one half-cycle after its edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      int r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if (timeout_flag !== e) begin
        errors++;
        $display("FAIL R%0d: timeout_flag=%0b expected %0b at %0t", r, timeout_flag, e, $time);
      end
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1);
    c_en = 1'b1; c_sel = 0; c_rel = 5;
    // R1: counter cleared by reset, hold before any boundary expires on first tick
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1);
    // R3: start reloads and clears flag
    step(0, 1, 0, 0, 3);
    // R5 R2: five held ticks at the fastest tap
    for (int i = 0; i < 14; i++) step(0, 0, 0, 1, 5);
    // R6: stays set during continued hold
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 6);
    // R3: acknowledge reloads; R4: hold toggling pauses count
    step(0, 0, 1, 0, 3);
    for (int i = 0; i < 24; i++) step(0, 0, 0, i[1], 4);
    // R7: disable drops flag and freezes count
    c_en = 1'b0;
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 7);
    c_en = 1'b1;
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 7);
    // R8: boundary pulses on every cycle of a hold, some coincide with ticks
    c_rel = 1;
    for (int i = 0; i < 12; i++) step(0, 1, 0, 1, 8);
    for (int i = 0; i < 12; i++) step(0, 0, i[0], 1, 8);
    // R2: slow tap, reload 3
    c_sel = 3; c_rel = 3;
    step(0, 1, 0, 0, 2);
    for (int i = 0; i < 70; i++) step(0, 0, 0, 1, 2);
    // R5: zero reload expires on first held tick
    c_sel = 1; c_rel = 0;
    step(0, 0, 1, 0, 5);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 5);
    // R1: reset mid-timeout clears flag
    step(1, 0, 0, 1, 1);
    step(1, 0, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule